// File: doc/BRIEF.md
# Message and Doorbell Interrupt Unit

This block is a register file that lets a host-side bus master and a local processor signal each other. Each direction has message registers (32 bits each by default, two of them), one doorbell register, one interrupt status register and one interrupt enable register. The host writes into the inbound set, and that raises interrupts towards the local processor. The local processor writes into the outbound set, and that raises interrupts towards the host. Each interrupt line is high while any status bit that is also enabled is set.

Both agents reach the block through one synchronous register port. A side-select input tells the block which agent is making the access, and it decides which register each offset maps to. Reading a doorbell returns its contents and empties it in the same access. Reading a status register returns the status ANDed with its enables and clears the status. Single-cycle event inputs from a neighbouring queue engine, and a machine-check input, set their own status bits.

Top module: `mdu_unit`

## Requirements
- R1: After reset all message, doorbell, status and enable registers are zero, and `host_irq` and `local_irq` are low.
- R2: A host write (side 0) to 0x50 or 0x54 stores inbound message 0 or 1 and sets inbound status bit 0 or 1. The local side reads these at the same offsets. A local write (side 1) to 0x58 or 0x5C stores outbound message 0 or 1 and sets outbound status bit 0 or 1. The host reads these at the same offsets.
- R3: A write to a message offset from the side that may only read it changes no message and sets no status bit.
- R4: A doorbell write ORs the data into the doorbell, so bits from separate writes accumulate. It sets status bit 3 of its direction only when the data is nonzero. The host writes the inbound doorbell at 0x68. The local side writes the outbound doorbell at 0x60.
- R5: A doorbell read returns the accumulated value and leaves the doorbell zero. The local side reads the inbound doorbell at 0x68. The host reads the outbound doorbell at 0x60.
- R6: A status read returns status AND enable and then clears every status bit. The local side reads inbound status at 0x100. The host reads outbound status at 0x30.
- R7: The enable registers can be read and written: inbound at local 0x104, outbound at host 0x34. Only defined bits are stored, so an enable reads back 0x1BB (inbound) or 0x02B (outbound) after an all-ones write. Bits 1:0 with value 1 enable message 0 only, value 2 enable message 1 only, and value 3 enable both.
- R8: One-cycle event inputs set status bits. `evt_out_post` sets outbound bit 5. `evt_mchk` sets inbound bit 4, `evt_in_post` sets inbound bit 5, `evt_in_post_ovf` sets inbound bit 7 and `evt_free_ovf` sets inbound bit 8.
- R9: `local_irq` is high when any bit of inbound status AND enable is set, and `host_irq` follows the same rule for the outbound direction. With the default `IRQ_REG = 0`, the line changes right after the clock edge that updates the status or enable register.
- R10: When an event sets a status bit in the same cycle as a clearing status read, the read returns the old value and the new bit stays set.
- R11: Offsets that are not mapped for the accessing side read as zero and clear nothing. Writes to them are ignored.
- R12: `acc_rdata` takes the read value at the rising edge that samples `acc_rd`, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_side | input | 1 | Accessing agent: 0 host, 1 local processor |
| acc_addr | input | ADDR_W | Byte offset of the access |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe, ignored while acc_wr is high |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Registered read data |
| evt_out_post | input | 1 | Outbound post-queue event pulse |
| evt_in_post | input | 1 | Inbound post-queue event pulse |
| evt_mchk | input | 1 | Machine-check event pulse |
| evt_in_post_ovf | input | 1 | Inbound post-queue overflow pulse |
| evt_free_ovf | input | 1 | Free-queue overflow pulse |
| host_irq | output | 1 | Interrupt towards the host |
| local_irq | output | 1 | Interrupt towards the local processor |

## Verification
The bound checker watches every cycle for the following:
- after a doorbell read or an event-free status read, the register is empty;
- a doorbell write leaves every written bit set;
- an event bit survives a coincident status read;
- a host write to an outbound message offset leaves that message unchanged;
- an enabled message write raises the local interrupt.

Only the directed scenarios can show the full data values, which are:
- the AND of status with the enable selector values 1, 2 and 3;
- the reserved-bit readback;
- the zero-data doorbell rule;
- the zero reads at offsets that are unmapped for one side but mapped for the other.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
   localparam int STAT_W     = 9;
   localparam int MSG_SLOTS  = 2;
   localparam int MSG_IDX_W  = 1;
   localparam int MSG_STRIDE = 4;

   localparam int unsigned OFF_IN_MSG  = 32'h050;
   localparam int unsigned OFF_OUT_MSG = 32'h058;
   localparam int unsigned OFF_OUT_DB  = 32'h060;
   localparam int unsigned OFF_IN_DB   = 32'h068;
   localparam int unsigned OFF_OUT_ST  = 32'h030;
   localparam int unsigned OFF_OUT_EN  = 32'h034;
   localparam int unsigned OFF_IN_ST   = 32'h100;
   localparam int unsigned OFF_IN_EN   = 32'h104;

   localparam int B_DB       = 3;
   localparam int B_MCHK     = 4;
   localparam int B_POST     = 5;
   localparam int B_POST_OVF = 7;
   localparam int B_FREE_OVF = 8;

   localparam logic [STAT_W-1:0] OUT_VALID = 9'h02B;
   localparam logic [STAT_W-1:0] IN_VALID  = 9'h1BB;

   typedef enum logic [3:0] {
      RS_ZERO, RS_IN_MSG, RS_OUT_MSG, RS_IN_DB, RS_OUT_DB,
      RS_IN_ST, RS_OUT_ST, RS_IN_EN, RS_OUT_EN
   } rsel_e;

   typedef struct packed {
      logic [MSG_SLOTS-1:0] msg_wr;
      logic                 db_wr;
      logic                 db_rd;
      logic                 st_rd;
      logic                 en_wr;
   } lane_acc_t;
endpackage

// File: rtl/mdu_decode.sv
module mdu_decode
   import mdu_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int NUM_MSG = 2
) (
   input  logic                 side,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wr,
   input  logic                 rd,
   output lane_acc_t            acc_in,
   output lane_acc_t            acc_out,
   output rsel_e                rsel,
   output logic [MSG_IDX_W-1:0] ridx
);
   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
      return 32'(a) == off;
   endfunction

   logic rd_req;
   assign rd_req = rd & ~wr;

   always_comb begin
      acc_in  = '0;
      acc_out = '0;
      rsel    = RS_ZERO;
      ridx    = '0;
      if (wr) begin
         if (!side) begin
            for (int i = 0; i < NUM_MSG; i++)
               if (hit(addr, OFF_IN_MSG + i * MSG_STRIDE)) acc_in.msg_wr[i] = 1'b1;
            if (hit(addr, OFF_IN_DB))  acc_in.db_wr  = 1'b1;
            if (hit(addr, OFF_OUT_EN)) acc_out.en_wr = 1'b1;
         end else begin
            for (int i = 0; i < NUM_MSG; i++)
               if (hit(addr, OFF_OUT_MSG + i * MSG_STRIDE)) acc_out.msg_wr[i] = 1'b1;
            if (hit(addr, OFF_OUT_DB)) acc_out.db_wr = 1'b1;
            if (hit(addr, OFF_IN_EN))  acc_in.en_wr  = 1'b1;
         end
      end else if (rd_req) begin
         if (!side) begin
            for (int i = 0; i < NUM_MSG; i++)
               if (hit(addr, OFF_OUT_MSG + i * MSG_STRIDE)) begin
                  rsel = RS_OUT_MSG;
                  ridx = MSG_IDX_W'(i);
               end
            if (hit(addr, OFF_OUT_DB)) begin
               rsel          = RS_OUT_DB;
               acc_out.db_rd = 1'b1;
            end
            if (hit(addr, OFF_OUT_ST)) begin
               rsel          = RS_OUT_ST;
               acc_out.st_rd = 1'b1;
            end
            if (hit(addr, OFF_OUT_EN)) rsel = RS_OUT_EN;
         end else begin
            for (int i = 0; i < NUM_MSG; i++)
               if (hit(addr, OFF_IN_MSG + i * MSG_STRIDE)) begin
                  rsel = RS_IN_MSG;
                  ridx = MSG_IDX_W'(i);
               end
            if (hit(addr, OFF_IN_DB)) begin
               rsel         = RS_IN_DB;
               acc_in.db_rd = 1'b1;
            end
            if (hit(addr, OFF_IN_ST)) begin
               rsel         = RS_IN_ST;
               acc_in.st_rd = 1'b1;
            end
            if (hit(addr, OFF_IN_EN)) rsel = RS_IN_EN;
         end
      end
   end
endmodule

// File: rtl/mdu_stat_reg.sv
module mdu_stat_reg
   import mdu_pkg::*;
#(
   parameter logic [STAT_W-1:0] VALID = IN_VALID
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] set,
   input  logic              clr,
   input  logic              en_wr,
   input  logic [STAT_W-1:0] en_data,
   output logic [STAT_W-1:0] stat,
   output logic [STAT_W-1:0] enable,
   output logic [STAT_W-1:0] masked
);
   logic [STAT_W-1:0] stat_q, en_q, stat_d;

   // a pending event outranks the clearing read
   always_comb begin
      stat_d = clr ? '0 : stat_q;
      stat_d = (stat_d | set) & VALID;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         en_q   <= '0;
      end else begin
         stat_q <= stat_d;
         if (en_wr) en_q <= en_data & VALID;
      end
   end

   assign stat   = stat_q;
   assign enable = en_q;
   assign masked = stat_q & en_q;
endmodule

// File: rtl/mdu_lane.sv
module mdu_lane
   import mdu_pkg::*;
#(
   parameter int                DATA_W  = 32,
   parameter int                NUM_MSG = 2,
   parameter logic [STAT_W-1:0] VALID   = IN_VALID,
   parameter bit                IRQ_REG = 1'b0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_MSG-1:0]              msg_wr,
   input  logic                            db_wr,
   input  logic                            db_rd,
   input  logic                            st_rd,
   input  logic                            en_wr,
   input  logic [DATA_W-1:0]               wdata,
   input  logic [STAT_W-1:0]               evt,
   output logic [NUM_MSG-1:0][DATA_W-1:0]  msg,
   output logic [DATA_W-1:0]               db,
   output logic [STAT_W-1:0]               stat,
   output logic [STAT_W-1:0]               enable,
   output logic [STAT_W-1:0]               masked,
   output logic                            irq
);
   for (genvar g = 0; g < NUM_MSG; g++) begin : g_msg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         q <= '0;
         else if (msg_wr[g]) q <= wdata;
      end
      assign msg[g] = q;
   end

   logic [DATA_W-1:0] db_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) db_q <= '0;
      else        db_q <= (db_rd ? '0 : db_q) | (db_wr ? wdata : '0);
   end
   assign db = db_q;

   logic [STAT_W-1:0] set_vec;
   always_comb begin
      set_vec = evt;
      for (int i = 0; i < NUM_MSG; i++) set_vec[i] = set_vec[i] | msg_wr[i];
      set_vec[B_DB] = set_vec[B_DB] | (db_wr & (|wdata));
   end

   mdu_stat_reg #(.VALID(VALID)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (set_vec),
      .clr     (st_rd),
      .en_wr   (en_wr),
      .en_data (wdata[STAT_W-1:0]),
      .stat    (stat),
      .enable  (enable),
      .masked  (masked)
   );

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |masked;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |masked;
   end
endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
   import mdu_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 12,
   parameter int NUM_MSG = 2,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_side,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_wr,
   input  logic              acc_rd,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   input  logic              evt_out_post,
   input  logic              evt_in_post,
   input  logic              evt_mchk,
   input  logic              evt_in_post_ovf,
   input  logic              evt_free_ovf,
   output logic              host_irq,
   output logic              local_irq
);
   if (DATA_W < STAT_W) begin : g_bad_data_w
      $error("mdu_unit: DATA_W must cover the status word");
   end
   if (ADDR_W < 9 || ADDR_W > 32) begin : g_bad_addr_w
      $error("mdu_unit: ADDR_W must lie in 9..32");
   end
   if (NUM_MSG < 1 || NUM_MSG > MSG_SLOTS) begin : g_bad_num_msg
      $error("mdu_unit: NUM_MSG must lie in 1..2");
   end

   lane_acc_t            acc_in, acc_out;
   rsel_e                rsel;
   logic [MSG_IDX_W-1:0] ridx;

   mdu_decode #(.ADDR_W(ADDR_W), .NUM_MSG(NUM_MSG)) u_dec (
      .side    (acc_side),
      .addr    (acc_addr),
      .wr      (acc_wr),
      .rd      (acc_rd),
      .acc_in  (acc_in),
      .acc_out (acc_out),
      .rsel    (rsel),
      .ridx    (ridx)
   );

   logic [STAT_W-1:0] in_evt, out_evt;
   always_comb begin
      in_evt             = '0;
      in_evt[B_MCHK]     = evt_mchk;
      in_evt[B_POST]     = evt_in_post;
      in_evt[B_POST_OVF] = evt_in_post_ovf;
      in_evt[B_FREE_OVF] = evt_free_ovf;
      out_evt            = '0;
      out_evt[B_POST]    = evt_out_post;
   end

   logic [NUM_MSG-1:0][DATA_W-1:0] in_msg_q, out_msg_q;
   logic [DATA_W-1:0]              in_db_q, out_db_q;
   logic [STAT_W-1:0]              in_stat_q, in_en_q, in_masked;
   logic [STAT_W-1:0]              out_stat_q, out_en_q, out_masked;

   mdu_lane #(.DATA_W(DATA_W), .NUM_MSG(NUM_MSG), .VALID(IN_VALID), .IRQ_REG(IRQ_REG)) u_in (
      .clk    (clk),
      .rst_n  (rst_n),
      .msg_wr (acc_in.msg_wr[NUM_MSG-1:0]),
      .db_wr  (acc_in.db_wr),
      .db_rd  (acc_in.db_rd),
      .st_rd  (acc_in.st_rd),
      .en_wr  (acc_in.en_wr),
      .wdata  (acc_wdata),
      .evt    (in_evt),
      .msg    (in_msg_q),
      .db     (in_db_q),
      .stat   (in_stat_q),
      .enable (in_en_q),
      .masked (in_masked),
      .irq    (local_irq)
   );

   mdu_lane #(.DATA_W(DATA_W), .NUM_MSG(NUM_MSG), .VALID(OUT_VALID), .IRQ_REG(IRQ_REG)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .msg_wr (acc_out.msg_wr[NUM_MSG-1:0]),
      .db_wr  (acc_out.db_wr),
      .db_rd  (acc_out.db_rd),
      .st_rd  (acc_out.st_rd),
      .en_wr  (acc_out.en_wr),
      .wdata  (acc_wdata),
      .evt    (out_evt),
      .msg    (out_msg_q),
      .db     (out_db_q),
      .stat   (out_stat_q),
      .enable (out_en_q),
      .masked (out_masked),
      .irq    (host_irq)
   );

   logic [DATA_W-1:0] rd_mux, rdata_q;
   always_comb begin
      case (rsel)
         RS_IN_MSG:  rd_mux = in_msg_q[ridx];
         RS_OUT_MSG: rd_mux = out_msg_q[ridx];
         RS_IN_DB:   rd_mux = in_db_q;
         RS_OUT_DB:  rd_mux = out_db_q;
         RS_IN_ST:   rd_mux = DATA_W'(in_masked);
         RS_OUT_ST:  rd_mux = DATA_W'(out_masked);
         RS_IN_EN:   rd_mux = DATA_W'(in_en_q);
         RS_OUT_EN:  rd_mux = DATA_W'(out_en_q);
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rdata_q <= '0;
      else if (acc_rd && !acc_wr) rdata_q <= rd_mux;
   end
   assign acc_rdata = rdata_q;
endmodule

// File: rtl/mdu_unit_chk.sv
module mdu_unit_chk #(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 12,
   parameter bit IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_side,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_wr,
   input logic              acc_rd,
   input logic [DATA_W-1:0] acc_wdata,
   input logic              evt_mchk,
   input logic              evt_in_post,
   input logic              evt_in_post_ovf,
   input logic              evt_free_ovf,
   input logic              local_irq,
   input logic [DATA_W-1:0] in_db,
   input logic [8:0]        in_stat,
   input logic [8:0]        in_en,
   input logic [DATA_W-1:0] out_msg0
);
   logic loc_rd, host_wr, any_in_evt;
   assign loc_rd     = acc_rd && !acc_wr && acc_side;
   assign host_wr    = acc_wr && !acc_side;
   assign any_in_evt = evt_mchk | evt_in_post | evt_in_post_ovf | evt_free_ovf;

   AST_DB_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_rd && acc_addr == ADDR_W'(12'h068)) |=> (in_db == '0)); // R5

   AST_DB_BITS_ACCUMULATE: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && acc_addr == ADDR_W'(12'h068)) |=> ((in_db & $past(acc_wdata)) == $past(acc_wdata))); // R4

   AST_STAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_rd && acc_addr == ADDR_W'(12'h100) && !any_in_evt) |=> (in_stat == '0)); // R6

   AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      evt_mchk |=> in_stat[4]); // R10

   AST_WRONG_SIDE_MSG: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && acc_addr == ADDR_W'(12'h058)) |=> $stable(out_msg0)); // R3

   if (!IRQ_REG) begin : g_irq_chk
      AST_ENABLED_MSG_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
         (host_wr && acc_addr == ADDR_W'(12'h050) && in_en[0]) |=> local_irq); // R9
   end
endmodule

bind mdu_unit mdu_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .acc_side        (acc_side),
   .acc_addr        (acc_addr),
   .acc_wr          (acc_wr),
   .acc_rd          (acc_rd),
   .acc_wdata       (acc_wdata),
   .evt_mchk        (evt_mchk),
   .evt_in_post     (evt_in_post),
   .evt_in_post_ovf (evt_in_post_ovf),
   .evt_free_ovf    (evt_free_ovf),
   .local_irq       (local_irq),
   .in_db           (in_db_q),
   .in_stat         (in_stat_q),
   .in_en           (in_en_q),
   .out_msg0        (out_msg_q[0])
);

// File: tb/sim_mdu_unit.sv
module sim_mdu_unit;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int AW = 12;
   localparam bit HOST = 1'b0;
   localparam bit LOC  = 1'b1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_side = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic          acc_wr = 1'b0, acc_rd = 1'b0;
   logic [DW-1:0] acc_wdata = '0;
   logic [DW-1:0] acc_rdata;
   logic          evt_out_post = 1'b0, evt_in_post = 1'b0, evt_mchk = 1'b0;
   logic          evt_in_post_ovf = 1'b0, evt_free_ovf = 1'b0;
   logic          host_irq, local_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   mdu_unit u0 (
      .clk(clk), .rst_n(rst_n), .acc_side(acc_side), .acc_addr(acc_addr),
      .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .evt_out_post(evt_out_post), .evt_in_post(evt_in_post), .evt_mchk(evt_mchk),
      .evt_in_post_ovf(evt_in_post_ovf), .evt_free_ovf(evt_free_ovf),
      .host_irq(host_irq), .local_irq(local_irq)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input bit side, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      acc_side = side; acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
      @(negedge clk);
      acc_wr = 1'b0;
   endtask

   task automatic rd(input bit side, input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      acc_side = side; acc_addr = a; acc_rd = 1'b1;
      @(negedge clk);
      acc_rd = 1'b0;
      d = acc_rdata;
   endtask

   task automatic rd_chk(input bit side, input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
      logic [DW-1:0] v;
      rd(side, a, v);
      check(tag, v, exp);
   endtask

   task automatic t_reset;
      check("R1 host_irq", {31'd0, host_irq}, 32'd0);
      check("R1 local_irq", {31'd0, local_irq}, 32'd0);
      rd_chk(LOC, 12'h100, 32'h0, "R1 inbound status");
      rd_chk(LOC, 12'h104, 32'h0, "R1 inbound enable");
      rd_chk(HOST, 12'h30, 32'h0, "R1 outbound status");
      rd_chk(LOC, 12'h68, 32'h0, "R1 inbound doorbell");
      rd_chk(HOST, 12'h58, 32'h0, "R1 outbound message 0");
   endtask

   task automatic t_inbound_msg;
      wr(HOST, 12'h50, 32'hA5A5_0001);
      rd_chk(LOC, 12'h50, 32'hA5A5_0001, "R2 inbound message 0");
      check("R9 masked status keeps local_irq low", {31'd0, local_irq}, 32'd0);
      wr(LOC, 12'h104, 32'h3);
      check("R9 enabling raises local_irq", {31'd0, local_irq}, 32'd1);
      rd_chk(LOC, 12'h104, 32'h3, "R7 enable readback value 3");
      wr(HOST, 12'h54, 32'h1234_5678);
      rd_chk(LOC, 12'h54, 32'h1234_5678, "R2 inbound message 1");
      rd_chk(LOC, 12'h100, 32'h3, "R6 inbound status both messages");
      check("R6 local_irq low after clearing read", {31'd0, local_irq}, 32'd0);
      rd_chk(LOC, 12'h100, 32'h0, "R6 inbound status cleared");
   endtask

   task automatic t_enable_select;
      wr(LOC, 12'h104, 32'h1);
      wr(HOST, 12'h54, 32'h7);
      check("R7 selector 1 masks message 1", {31'd0, local_irq}, 32'd0);
      wr(HOST, 12'h50, 32'h1111_0000);
      check("R7 selector 1 passes message 0", {31'd0, local_irq}, 32'd1);
      rd_chk(LOC, 12'h100, 32'h1, "R7 status AND selector 1");
      wr(LOC, 12'h104, 32'h2);
      wr(HOST, 12'h50, 32'h1111_0000);
      check("R7 selector 2 masks message 0", {31'd0, local_irq}, 32'd0);
      wr(HOST, 12'h54, 32'h8);
      rd_chk(LOC, 12'h100, 32'h2, "R7 status AND selector 2");
      wr(LOC, 12'h104, 32'hFFFF_FFFF);
      rd_chk(LOC, 12'h104, 32'h1BB, "R7 inbound reserved enable bits zero");
   endtask

   task automatic t_outbound_msg;
      wr(HOST, 12'h34, 32'hFFFF_FFFF);
      rd_chk(HOST, 12'h34, 32'h2B, "R7 outbound reserved enable bits zero");
      check("R9 host_irq idle", {31'd0, host_irq}, 32'd0);
      wr(LOC, 12'h58, 32'hCAFE_0000);
      check("R9 outbound message raises host_irq", {31'd0, host_irq}, 32'd1);
      wr(LOC, 12'h5C, 32'h0BAD_F00D);
      rd_chk(HOST, 12'h58, 32'hCAFE_0000, "R2 outbound message 0");
      rd_chk(HOST, 12'h5C, 32'h0BAD_F00D, "R2 outbound message 1");
      rd_chk(HOST, 12'h30, 32'h3, "R6 outbound status");
      check("R6 host_irq low after clearing read", {31'd0, host_irq}, 32'd0);
   endtask

   task automatic t_wrong_side;
      wr(HOST, 12'h58, 32'h0000_DEAD);
      rd_chk(HOST, 12'h58, 32'hCAFE_0000, "R3 host write to outbound message ignored");
      rd_chk(HOST, 12'h30, 32'h0, "R3 host write sets no outbound status");
      wr(LOC, 12'h50, 32'h0000_BEEF);
      rd_chk(LOC, 12'h50, 32'h1111_0000, "R3 local write to inbound message ignored");
      rd_chk(LOC, 12'h100, 32'h0, "R3 local write sets no inbound status");
   endtask

   task automatic t_doorbell;
      wr(LOC, 12'h60, 32'h0000_0001);
      wr(LOC, 12'h60, 32'h0000_0100);
      rd_chk(HOST, 12'h60, 32'h0000_0101, "R4 outbound doorbell accumulates");
      rd_chk(HOST, 12'h60, 32'h0, "R5 outbound doorbell cleared by read");
      rd_chk(HOST, 12'h30, 32'h8, "R4 outbound doorbell status bit 3");
      wr(LOC, 12'h60, 32'h0);
      rd_chk(HOST, 12'h30, 32'h0, "R4 zero doorbell write sets no status");
      wr(HOST, 12'h68, 32'h4);
      check("R4 inbound doorbell raises local_irq", {31'd0, local_irq}, 32'd1);
      rd_chk(LOC, 12'h68, 32'h4, "R5 inbound doorbell value");
      rd_chk(LOC, 12'h68, 32'h0, "R5 inbound doorbell cleared by read");
      rd_chk(LOC, 12'h100, 32'h8, "R4 inbound doorbell status bit 3");
   endtask

   task automatic t_events;
      @(negedge clk); evt_out_post = 1'b1;
      @(negedge clk); evt_out_post = 1'b0;
      check("R8 outbound post event raises host_irq", {31'd0, host_irq}, 32'd1);
      rd_chk(HOST, 12'h30, 32'h20, "R8 outbound post bit 5");
      @(negedge clk);
      evt_mchk = 1'b1; evt_in_post = 1'b1; evt_in_post_ovf = 1'b1; evt_free_ovf = 1'b1;
      @(negedge clk);
      evt_mchk = 1'b0; evt_in_post = 1'b0; evt_in_post_ovf = 1'b0; evt_free_ovf = 1'b0;
      rd_chk(LOC, 12'h100, 32'h1B0, "R8 inbound event bits 4 5 7 8");
   endtask

   task automatic t_collision;
      logic [DW-1:0] v;
      @(negedge clk);
      acc_side = LOC; acc_addr = 12'h100; acc_rd = 1'b1; evt_mchk = 1'b1;
      @(negedge clk);
      acc_rd = 1'b0; evt_mchk = 1'b0;
      v = acc_rdata;
      check("R10 colliding read returns old status", v, 32'h0);
      check("R10 event bit kept, local_irq high", {31'd0, local_irq}, 32'd1);
      rd_chk(LOC, 12'h100, 32'h10, "R10 machine check bit survived");
   endtask

   task automatic t_unmapped;
      wr(LOC, 12'h58, 32'h1);
      rd_chk(LOC, 12'h30, 32'h0, "R11 local read of outbound status is zero");
      rd_chk(HOST, 12'h30, 32'h1, "R11 outbound status not cleared by local side");
      wr(HOST, 12'h200, 32'hFFFF_FFFF);
      rd_chk(HOST, 12'h200, 32'h0, "R11 unmapped offset reads zero");
      wr(LOC, 12'h60, 32'h40);
      rd_chk(LOC, 12'h60, 32'h0, "R11 local read of outbound doorbell is zero");
      rd_chk(HOST, 12'h60, 32'h40, "R11 outbound doorbell not cleared by local side");
   endtask

   task automatic t_hold;
      rd_chk(HOST, 12'h58, 32'h0000_0001, "R12 read value");
      repeat (3) @(negedge clk);
      check("R12 read data held while idle", acc_rdata, 32'h0000_0001);
      wr(LOC, 12'h5C, 32'h5555_AAAA);
      check("R12 read data held across a write", acc_rdata, 32'h0000_0001);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_inbound_msg();
      t_enable_select();
      t_outbound_msg();
      t_wrong_side();
      t_doorbell();
      t_events();
      t_collision();
      t_unmapped();
      t_hold();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog all requirements actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule